// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This block keeps the four 9-bit registers that set how close to empty and how close to full a synchronous FIFO must be before its almost-empty and almost-full flags assert. Each threshold is split across a low register and a high register. All four registers share one 9-bit input path and one 9-bit output path, and a cyclic slot pointer on each side selects the register. While the load strobe and the first write enable are both low, each write-clock edge stores the input word in the current slot and steps the pointer. While the load strobe and both read enables are low, each read-clock edge places the current slot's contents on the output and steps a separate read pointer through the same order.

The pointers are not reset at the start of a session. Software can load or read a few slots, leave load mode, and carry on later from where it stopped. The offset width is `$clog2(DEPTH)`. Bits above that width are never stored and always read as zero. The assembled empty and full thresholds go out as full-width values for the flag comparators.

A load and a readback in the same cycle is not a legal use. If it happens anyway, the load is carried out, the readback is suppressed, and an error pulse is raised.

Top module: `ofs_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge, the low-half registers (slots 0 and 2) take 007h and the high-half registers (slots 1 and 3) take 0. Both pointers go to slot 0, `dout` goes to 0, and `dout_sel` and `clash_err` go low.
- R2: At a `wclk` edge where `ld_n`=0 and `wen1_n`=0, `din` (masked per R8) is stored into the slot under the write pointer, and the write pointer advances by one.
- R3: Slot order is 0 = empty-threshold low half, 1 = empty-threshold high half, 2 = full-threshold low half, 3 = full-threshold high half. The slot after 3 is 0, so a fifth load lands in slot 0.
- R4: At a `wclk` edge where `ld_n`=1 or `wen1_n`=1, no register changes and the write pointer holds.
- R5: The write pointer and the read pointer keep their positions when `ld_n` goes high. The next session continues at the following slot.
- R6: At an `rclk` edge where `ld_n`=0, `ren1_n`=0, `ren2_n`=0 and no load is taking place, `dout` takes the zero-extended contents of the slot under the read pointer. The read pointer then advances in the R3 order, and `dout_sel` is high for the cycle that follows.
- R7: At an `rclk` edge without a readback, `dout` holds its value, `dout_sel` is low, and the read pointer holds.
- R8: With W = `$clog2(DEPTH)`, the low-half slots keep bits [min(W,9)-1:0] and the high-half slots keep bits [W-10:0], or nothing when W ≤ 9. All other bits read as 0. For DEPTH=1024 the low halves keep 9 bits and the high halves keep 1 bit.
- R9: `empty_ofs` is the low W bits of {slot1, slot0}, and `full_ofs` is the low W bits of {slot3, slot2}.
- R10: When `ld_n`, `wen1_n`, `ren1_n` and `ren2_n` are all 0 at an edge, the load is performed and the readback is not: `dout` holds, `dout_sel` stays low and the read pointer holds. `clash_err` is high for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both domains |
| ld_n | input | 1 | Offset access strobe, active low |
| wen1_n | input | 1 | First write enable, active low |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| din | input | 9 | Shared data input |
| dout | output | 9 | Readback data |
| dout_sel | output | 1 | High while `dout` carries offset readback data |
| empty_ofs | output | $clog2(DEPTH) | Assembled almost-empty threshold |
| full_ofs | output | $clog2(DEPTH) | Assembled almost-full threshold |
| clash_err | output | 1 | Simultaneous load and readback was attempted |

## Verification
The bench aims at the fifth load and the fourth readback, where the pointers wrap. A design that saturated or reset the pointer there would write or return the wrong slot. It splits loads across sessions to catch a pointer that restarts at slot 0 whenever `ld_n` rises. It writes all-ones into the high halves, which exposes storage of bits above the offset width. It also drives a simultaneous load and readback, where a wrong design would advance the read pointer or raise `dout_sel`, and every later readback would then come back one slot off.

// File: rtl/ofs_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the threshold offset loader.
package ofs_pkg;
    localparam int OFS_DW    = 9;  // width of the shared data path
    localparam int OFS_SLOTS = 4;  // number of offset registers

    // Slot numbering; the order is the load and readback sequence
    typedef enum logic [1:0] {
        SLOT_EMPTY_LO = 2'd0,
        SLOT_EMPTY_HI = 2'd1,
        SLOT_FULL_LO  = 2'd2,
        SLOT_FULL_HI  = 2'd3
    } slot_e;
endpackage

// File: rtl/ofs_seq_ptr.sv
`timescale 1ns/1ps
// Cyclic slot pointer: a 2-bit counter stepping 0,1,2,3,0 on each
// advance request. Assumes adv is synchronous to clk.
module ofs_seq_ptr
    import ofs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv,
    output logic [1:0]  slot
);

    // Step or hold the pointer; reset returns it to the first slot
    always_ff @(posedge clk) begin
        if (!rst_n)   slot <= SLOT_EMPTY_LO;
        else if (adv) slot <= slot + 2'd1;
    end

    p_step_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (slot == 2'(($past(slot) + 2'd1))));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(slot));

endmodule

// File: rtl/ofs_reg_bank.sv
`timescale 1ns/1ps
// Four offset registers written one at a time through a slot select.
// Each slot keeps only the bits that the configured offset width uses.
// Assumes we and wsel are synchronous to clk.
module ofs_reg_bank
    import ofs_pkg::*;
#(
    parameter int DW    = OFS_DW,
    parameter int LSB_W = 9,
    parameter int MSB_W = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [1:0]                 wsel,
    input  logic [DW-1:0]              din,
    output logic [OFS_SLOTS*DW-1:0]    regs_flat
);

    localparam logic [DW-1:0] LSB_MASK = DW'((32'd1 << LSB_W) - 32'd1);
    localparam logic [DW-1:0] MSB_MASK = DW'((32'd1 << MSB_W) - 32'd1);
    localparam logic [DW-1:0] LSB_INIT = DW'(7) & LSB_MASK;

    for (genvar k = 0; k < OFS_SLOTS; k++) begin : g_slot
        localparam logic [DW-1:0] MASK = (k % 2 == 1) ? MSB_MASK : LSB_MASK;
        localparam logic [DW-1:0] INIT = (k % 2 == 1) ? '0 : LSB_INIT;
        logic [DW-1:0] q;

        // Load this slot when it is selected, keeping only used bits
        always_ff @(posedge clk) begin
            if (!rst_n)                         q <= INIT;
            else if (we && (wsel == 2'(k)))     q <= din & MASK;
        end

        assign regs_flat[k*DW +: DW] = q;

        p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (regs_flat[k*DW +: DW] & ~MASK) == '0);
    end

    p_no_load_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_flat));

endmodule

// File: rtl/ofs_readback.sv
`timescale 1ns/1ps
// Read-clock output stage: on a read strobe it registers the selected
// slot onto dout and raises dout_sel for one cycle. Assumes the register
// contents are not changing while readback runs.
module ofs_readback
    import ofs_pkg::*;
#(
    parameter int DW = OFS_DW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd,
    input  logic [1:0]                 rsel,
    input  logic [OFS_SLOTS*DW-1:0]    regs_flat,
    output logic [DW-1:0]              dout,
    output logic                       dout_sel
);

    // Capture the selected register on a readback edge, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)  dout <= '0;
        else if (rd) dout <= regs_flat[rsel*DW +: DW];
    end

    // Mark the cycle after a readback edge as offset data on dout
    always_ff @(posedge clk) begin
        if (!rst_n) dout_sel <= 1'b0;
        else        dout_sel <= rd;
    end

    p_sel_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> dout_sel);
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (!dout_sel && $stable(dout)));

endmodule

// File: rtl/ofs_loader.sv
`timescale 1ns/1ps
// Threshold offset loader for a 9-bit synchronous FIFO. Loads four offset
// registers in cyclic order on wclk and reads them back in the same order
// on rclk, with a pointer per clock domain. Assumes loads and readbacks do
// not overlap; if they do, the load wins and clash_err pulses.
module ofs_loader
    import ofs_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic                        wclk,
    input  logic                        rclk,
    input  logic                        rst_n,
    input  logic                        ld_n,
    input  logic                        wen1_n,
    input  logic                        ren1_n,
    input  logic                        ren2_n,
    input  logic [8:0]                  din,
    output logic [8:0]                  dout,
    output logic                        dout_sel,
    output logic [$clog2(DEPTH)-1:0]    empty_ofs,
    output logic [$clog2(DEPTH)-1:0]    full_ofs,
    output logic                        clash_err
);

    localparam int OFS_W = $clog2(DEPTH);
    localparam int LSB_W = (OFS_W > OFS_DW) ? OFS_DW : OFS_W;
    localparam int MSB_W = (OFS_W > OFS_DW) ? OFS_W - OFS_DW : 0;

    logic                          wr_stb;
    logic                          rd_req;
    logic                          rd_stb;
    logic [1:0]                    wslot;
    logic [1:0]                    rslot;
    logic [OFS_SLOTS*OFS_DW-1:0]   regs_flat;

    // Decode the access strobes; a load blocks a readback
    always_comb begin
        wr_stb = !ld_n && !wen1_n;
        rd_req = !ld_n && !ren1_n && !ren2_n;
        rd_stb = rd_req && !wr_stb;
    end

    ofs_seq_ptr u_wptr (
        .clk   (wclk),
        .rst_n (rst_n),
        .adv   (wr_stb),
        .slot  (wslot)
    );

    ofs_seq_ptr u_rptr (
        .clk   (rclk),
        .rst_n (rst_n),
        .adv   (rd_stb),
        .slot  (rslot)
    );

    ofs_reg_bank #(
        .DW    (OFS_DW),
        .LSB_W (LSB_W),
        .MSB_W (MSB_W)
    ) u_bank (
        .clk       (wclk),
        .rst_n     (rst_n),
        .we        (wr_stb),
        .wsel      (wslot),
        .din       (din),
        .regs_flat (regs_flat)
    );

    ofs_readback #(
        .DW (OFS_DW)
    ) u_rdbk (
        .clk       (rclk),
        .rst_n     (rst_n),
        .rd        (rd_stb),
        .rsel      (rslot),
        .regs_flat (regs_flat),
        .dout      (dout),
        .dout_sel  (dout_sel)
    );

    // Assemble the thresholds from their high and low halves
    assign empty_ofs = OFS_W'({regs_flat[2*OFS_DW-1:OFS_DW], regs_flat[OFS_DW-1:0]});
    assign full_ofs  = OFS_W'({regs_flat[4*OFS_DW-1:3*OFS_DW], regs_flat[3*OFS_DW-1:2*OFS_DW]});

    // Flag a simultaneous load and readback request for one cycle
    always_ff @(posedge wclk) begin
        if (!rst_n) clash_err <= 1'b0;
        else        clash_err <= wr_stb && rd_req;
    end

    p_clash_flag_r10: assert property (@(posedge wclk) disable iff (!rst_n)
        (!ld_n && !wen1_n && !ren1_n && !ren2_n) |=> clash_err);
    p_clash_no_read_r10: assert property (@(posedge rclk) disable iff (!rst_n)
        (!ld_n && !wen1_n && !ren1_n && !ren2_n) |=> !dout_sel);
    p_load_only_in_mode_r2: assert property (@(posedge wclk) disable iff (!rst_n)
        ld_n |=> $stable(empty_ofs) && $stable(full_ofs));

endmodule

// File: tb/ofs_loader_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task models the slots and pushes expected
// readback words; a monitor pops them whenever dout_sel is high.
module ofs_loader_tb;
    localparam int DEPTH = 1024;
    localparam int DW    = 9;
    localparam int W     = $clog2(DEPTH);
    localparam int LW    = (W > DW) ? DW : W;
    localparam int MW    = (W > DW) ? W - DW : 0;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          ld_n = 1'b1, wen1_n = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_sel;
    logic [W-1:0]  empty_ofs, full_ofs;
    logic          clash_err;

    ofs_loader #(.DEPTH(DEPTH)) u_dut (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .ld_n(ld_n), .wen1_n(wen1_n),
        .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din), .dout(dout),
        .dout_sel(dout_sel), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .clash_err(clash_err)
    );

    int            n_chk = 0, n_fail = 0;
    logic [DW-1:0] m [4];
    int            wp = 0, rp = 0;
    logic [DW-1:0] exp_q [$];
    logic [DW-1:0] last_dout = '0;
    bit            done = 0;

    function automatic logic [DW-1:0] keep(int bits);
        return DW'((32'd1 << bits) - 32'd1);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_ofs(string req);
        check({req, " empty_ofs"}, int'(empty_ofs), int'(W'({m[1], m[0]})));
        check({req, " full_ofs"},  int'(full_ofs),  int'(W'({m[3], m[2]})));
    endtask

    // Drive one cycle, update the model, check the cycle's side results
    task automatic cyc(bit ld, bit w1, bit r1, bit r2, logic [DW-1:0] d, string req);
        bit wr, rd, clash;
        @(negedge clk);
        ld_n = ld; wen1_n = w1; ren1_n = r1; ren2_n = r2; din = d;
        wr    = !ld && !w1;
        clash = wr && !r1 && !r2;
        rd    = !ld && !r1 && !r2 && !wr;
        if (rd) begin
            exp_q.push_back(m[rp]);
            last_dout = m[rp];
            rp = (rp + 1) % 4;
        end
        if (wr) begin
            m[wp] = d & ((wp % 2 == 1) ? keep(MW) : keep(LW));
            wp = (wp + 1) % 4;
        end
        @(posedge clk); #1;
        check({req, " clash_err"}, int'(clash_err), int'(clash));
        if (!rd) begin
            check({req, " dout_sel low"}, int'(dout_sel), 0);
            check({req, " dout held"}, int'(dout), int'(last_dout));
        end
    endtask

    // Monitor: compare each readback word against the scoreboard
    always @(negedge clk) begin
        if (rst_n && dout_sel) begin
            if (exp_q.size() == 0) check("R6 unexpected readback", 1, 0);
            else check("R6 readback data", int'(dout), int'(exp_q.pop_front()));
        end
    end

    initial begin
        m[0] = 9'h007; m[1] = 9'h000; m[2] = 9'h007; m[3] = 9'h000;
        repeat (3) @(posedge clk);
        #1;
        check("R1 dout reset", int'(dout), 0);
        check("R1 dout_sel reset", int'(dout_sel), 0);
        check("R1 clash_err reset", int'(clash_err), 0);
        chk_ofs("R1 defaults");
        @(negedge clk) rst_n = 1'b1;

        // R1/R6: read defaults starting at slot 0, then wrap
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, '0, "R6");
        // R2/R3/R8: full load session, high halves get masked
        cyc(0, 0, 1, 1, 9'h1A5, "R2");
        cyc(0, 0, 1, 1, 9'h0FF, "R8");
        cyc(0, 0, 1, 1, 9'h123, "R2");
        cyc(0, 0, 1, 1, 9'h002, "R8");
        chk_ofs("R9 after four loads");
        cyc(0, 0, 1, 1, 9'h055, "R3");
        chk_ofs("R3 fifth load wraps");
        // R4: no load when either strobe is high
        cyc(1, 0, 1, 1, 9'h1EE, "R4");
        cyc(0, 1, 1, 1, 9'h1DD, "R4");
        cyc(1, 1, 1, 1, 9'h1CC, "R4");
        chk_ofs("R4 ignored writes");
        // R5: partial sessions continue the sequence
        cyc(0, 0, 1, 1, 9'h1FF, "R5");
        cyc(1, 1, 1, 1, 9'h000, "R5");
        cyc(0, 0, 1, 1, 9'h0AA, "R5");
        chk_ofs("R5 partial sessions");
        // R6: readback across the wrap
        for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0, '0, "R6");
        cyc(1, 1, 1, 1, '0, "R5");
        cyc(0, 1, 0, 0, '0, "R5");
        // R7: one enable or the strobe high blocks readback
        cyc(0, 1, 1, 0, '0, "R7");
        cyc(0, 1, 0, 1, '0, "R7");
        cyc(1, 1, 0, 0, '0, "R7");
        // R10: simultaneous load and readback
        cyc(0, 0, 0, 0, 9'h1C3, "R10");
        chk_ofs("R10 load performed");
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, '0, "R10");
        cyc(1, 1, 1, 1, '0, "R7");
        cyc(1, 1, 1, 1, '0, "R7");
        check("R6 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule